// File: doc/BRIEF.md
# Mailbox Receive Register Bank

This block is the receiving end of an inter-processor mailbox. Each of two sending processors owns four mailbox channels in this bank. A sender raises event flags in a channel with one-cycle set pulses, and it drives command, address and data words that the bank mirrors for the local processor to read. The local processor reads the flags through a read-only status register and acknowledges them by writing ones to a separate acknowledge register. It reads the mirrored message words and leaves a reply word that is presented back to the sender.

Flag 0 of each channel drives a level interrupt to the local processor. The interrupt stays high until software acknowledges that flag. Access is through a single-cycle register bus. Read data is registered and appears on the cycle after the request. A channel's registers lie at a fixed stride, and the second sender's channels lie in a bank above the first.

Top module: `mbox_rx_port`

## Requirements
- R1: Each channel holds 32 event flags, and all are zero after reset. A 1 on bit n of the channel's set-pulse input sets flag n at that clock edge. Flags change only through set pulses and acknowledge writes. The status register (offset 0x0) returns the flags and is read-only.
- R2: Writing the acknowledge register (offset 0x4) clears every flag whose bit in the write data is 1. Bits written as 0 leave their flags unchanged.
- R3: If a set pulse and an acknowledge clear hit the same flag in the same cycle, the flag ends up set.
- R4: A read of the acknowledge register always returns zero.
- R5: The command (0x10), address (0x14) and data (0x18) registers are read-only 32-bit copies of the sender's command, address and data inputs. They are captured on every clock and are zero after reset. Writes to them change nothing.
- R6: The reply register (0x1C) is a 32-bit read/write word that resets to zero. Its value is driven on the channel's reply output from the edge that writes it.
- R7: Channel k = 4*s + i (sender s in 0..1, instance i in 0..3) sits at byte address 0x2000*s + 0x800*i plus the register offset. Its slice on every flattened port is bits [32k+31:32k], and its interrupt is bit k of `irq`.
- R8: A read of a reserved offset within a channel (0x8, 0xC, any unaligned or any other unlisted offset) returns zero. Writes to reserved offsets and to the status register change no state.
- R9: `irq[k]` is high exactly while flag 0 of channel k is set. It falls in the cycle after the edge at which an acknowledge write clears that flag.
- R10: Read data appears on `bus_rdata` in the cycle after a read request and is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 14 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| evt_set | input | 256 | Per-channel flag set pulses, 32 bits per channel |
| snd_cmd | input | 256 | Sender command words, 32 bits per channel |
| snd_addr | input | 256 | Sender address words, 32 bits per channel |
| snd_data | input | 256 | Sender data words, 32 bits per channel |
| reply_word | output | 256 | Reply words back to the senders, 32 bits per channel |
| irq | output | 8 | Per-channel interrupt from flag 0 |

## Verification
Four kinds of result are due at different times. A set pulse or an acknowledge write shows up in the flags and in `irq` right after the edge that samples it. A sender word reaches its mirror register one edge after it is driven, so a read issued at the next falling edge returns it on the edge after that. A reply write reaches `reply_word` at the edge that accepts the write. Read data always lags the request by exactly one edge. The behavioural model in the bench applies the same edge-by-edge updates and is compared 1 ns after each rising edge. The directed reads sample `bus_rdata` at the falling edge that follows the edge which captured them.

// File: rtl/mbox_rx_pkg.sv
`timescale 1ns/1ps
package mbox_rx_pkg;

   // Register kinds decoded from the in-channel offset
   typedef enum logic [2:0] {
      RK_NONE,
      RK_STATUS,
      RK_ACK,
      RK_CMD,
      RK_ADDR,
      RK_DATA,
      RK_REPLY
   } reg_kind_e;

   // Byte offsets inside one channel window
   localparam int OFF_STATUS = 'h00;
   localparam int OFF_ACK    = 'h04;
   localparam int OFF_CMD    = 'h10;
   localparam int OFF_ADDR   = 'h14;
   localparam int OFF_DATA   = 'h18;
   localparam int OFF_REPLY  = 'h1C;

endpackage

// File: rtl/mbox_rx_decode.sv
`timescale 1ns/1ps
module mbox_rx_decode
   import mbox_rx_pkg::*;
#(
   parameter int ADDR_W      = 14,
   parameter int INST_SHIFT  = 11,
   parameter int INST_W      = 2,
   parameter int SND_SHIFT   = 13,
   parameter int SND_W       = 1,
   parameter int NUM_SENDERS = 2
) (
   input  logic [ADDR_W-1:0]       addr,
   output logic                    hit,
   output logic [SND_W+INST_W-1:0] chan,
   output reg_kind_e               kind
);

   logic [INST_SHIFT-1:0] off;
   logic [SND_SHIFT-1:0]  low_part;
   logic [SND_W-1:0]      snd;
   logic                  gap_ok;
   logic                  top_ok;
   logic                  snd_ok;

   always_comb begin
      off      = addr[INST_SHIFT-1:0];
      low_part = addr[SND_SHIFT-1:0];
      snd      = addr[SND_SHIFT +: SND_W];
      // bits between the instance field and the sender field must be zero
      gap_ok   = ((low_part >> (INST_SHIFT + INST_W)) == '0);
      top_ok   = ((addr >> (SND_SHIFT + SND_W)) == '0);
      snd_ok   = (int'(snd) < NUM_SENDERS);

      if      (off == INST_SHIFT'(OFF_STATUS)) kind = RK_STATUS;
      else if (off == INST_SHIFT'(OFF_ACK))    kind = RK_ACK;
      else if (off == INST_SHIFT'(OFF_CMD))    kind = RK_CMD;
      else if (off == INST_SHIFT'(OFF_ADDR))   kind = RK_ADDR;
      else if (off == INST_SHIFT'(OFF_DATA))   kind = RK_DATA;
      else if (off == INST_SHIFT'(OFF_REPLY))  kind = RK_REPLY;
      else                                     kind = RK_NONE;

      hit  = gap_ok && top_ok && snd_ok && (kind != RK_NONE);
      chan = {snd, addr[INST_SHIFT +: INST_W]};
   end

endmodule

// File: rtl/mbox_rx_channel.sv
`timescale 1ns/1ps
module mbox_rx_channel
   import mbox_rx_pkg::*;
#(
   parameter int FLAG_W         = 32,
   parameter int DATA_W         = 32,
   parameter bit CAPTURE_MIRROR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_hit,
   input  logic              acc_we,
   input  reg_kind_e         acc_kind,
   input  logic [DATA_W-1:0] acc_wdata,
   input  logic [FLAG_W-1:0] set_pulse,
   input  logic [DATA_W-1:0] cmd_in,
   input  logic [DATA_W-1:0] adr_in,
   input  logic [DATA_W-1:0] dat_in,
   output logic [DATA_W-1:0] rd_word,
   output logic              irq,
   output logic [DATA_W-1:0] reply_out
);

   logic [FLAG_W-1:0] flags_q;
   logic [FLAG_W-1:0] ack_mask;
   logic [DATA_W-1:0] reply_q;
   logic [DATA_W-1:0] cmd_m;
   logic [DATA_W-1:0] adr_m;
   logic [DATA_W-1:0] dat_m;
   logic              ack_we;
   logic              reply_we;

   assign ack_we   = acc_hit && acc_we && (acc_kind == RK_ACK);
   assign reply_we = acc_hit && acc_we && (acc_kind == RK_REPLY);
   assign ack_mask = ack_we ? acc_wdata[FLAG_W-1:0] : '0;

   // set is OR-ed after the clear so a coincident set survives
   always_ff @(posedge clk) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~ack_mask) | set_pulse;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        reply_q <= '0;
      else if (reply_we) reply_q <= acc_wdata;
   end

   generate
      if (CAPTURE_MIRROR) begin : g_mirror_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cmd_m <= '0;
               adr_m <= '0;
               dat_m <= '0;
            end else begin
               cmd_m <= cmd_in;
               adr_m <= adr_in;
               dat_m <= dat_in;
            end
         end
      end else begin : g_mirror_wire
         assign cmd_m = cmd_in;
         assign adr_m = adr_in;
         assign dat_m = dat_in;
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      if (acc_hit && !acc_we) begin
         case (acc_kind)
            RK_STATUS: rd_word = DATA_W'(flags_q);
            RK_CMD:    rd_word = cmd_m;
            RK_ADDR:   rd_word = adr_m;
            RK_DATA:   rd_word = dat_m;
            RK_REPLY:  rd_word = reply_q;
            default:   rd_word = '0;
         endcase
      end
   end

   assign irq       = flags_q[0];
   assign reply_out = reply_q;

   // R2: acknowledged bits not re-set in the same cycle are clear afterwards
   a_r2_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack_we |=> ((flags_q & $past(acc_wdata[FLAG_W-1:0] & ~set_pulse)) == '0));

   // R3: every pulsed bit is set after the edge, whatever was acknowledged
   a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_pulse != '0) |=> ((flags_q & $past(set_pulse)) == $past(set_pulse)));

   // R1: flags only move through set pulses or acknowledge writes
   a_r1_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_we && (set_pulse == '0)) |=> $stable(flags_q));

   // R9: the interrupt only falls after an acknowledge of flag 0
   a_r9_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(ack_we && acc_wdata[0]));

   // R6: reply word changes only through a reply write
   a_r6_reply_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reply_we |=> $stable(reply_out));

endmodule

// File: rtl/mbox_rx_port.sv
`timescale 1ns/1ps
module mbox_rx_port
   import mbox_rx_pkg::*;
#(
   parameter int NUM_SENDERS    = 2,
   parameter int NUM_INST       = 4,
   parameter int FLAG_W         = 32,
   parameter int DATA_W         = 32,
   parameter int INST_STRIDE    = 'h800,
   parameter int SENDER_STRIDE  = 'h2000,
   parameter int ADDR_W         = 14,
   parameter bit CAPTURE_MIRROR = 1'b1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   bus_sel,
   input  logic                                   bus_we,
   input  logic [ADDR_W-1:0]                      bus_addr,
   input  logic [DATA_W-1:0]                      bus_wdata,
   output logic [DATA_W-1:0]                      bus_rdata,
   input  logic [NUM_SENDERS*NUM_INST*FLAG_W-1:0] evt_set,
   input  logic [NUM_SENDERS*NUM_INST*DATA_W-1:0] snd_cmd,
   input  logic [NUM_SENDERS*NUM_INST*DATA_W-1:0] snd_addr,
   input  logic [NUM_SENDERS*NUM_INST*DATA_W-1:0] snd_data,
   output logic [NUM_SENDERS*NUM_INST*DATA_W-1:0] reply_word,
   output logic [NUM_SENDERS*NUM_INST-1:0]        irq
);

   localparam int NCH        = NUM_SENDERS * NUM_INST;
   localparam int INST_SHIFT = $clog2(INST_STRIDE);
   localparam int SND_SHIFT  = $clog2(SENDER_STRIDE);
   localparam int INST_W     = $clog2(NUM_INST);
   localparam int SND_W      = (NUM_SENDERS > 1) ? $clog2(NUM_SENDERS) : 1;
   localparam int CH_W       = SND_W + INST_W;

   // elaboration-time parameter checks
   generate
      if ((1 << INST_SHIFT) != INST_STRIDE)
         $error("INST_STRIDE must be a power of two");
      if ((1 << SND_SHIFT) != SENDER_STRIDE)
         $error("SENDER_STRIDE must be a power of two");
      if (INST_SHIFT < 5)
         $error("INST_STRIDE too small for the register window");
      if (NUM_INST < 2 || (1 << INST_W) != NUM_INST)
         $error("NUM_INST must be a power of two of at least 2");
      if (INST_SHIFT + INST_W > SND_SHIFT)
         $error("instance windows overlap the next sender bank");
      if (ADDR_W < SND_SHIFT + SND_W)
         $error("ADDR_W cannot reach every sender bank");
      if (FLAG_W > DATA_W || FLAG_W < 1)
         $error("FLAG_W must lie in 1..DATA_W");
   endgenerate

   logic             dec_hit;
   logic [CH_W-1:0]  dec_chan;
   reg_kind_e        dec_kind;
   logic [NCH-1:0]   chan_hit;
   logic [DATA_W-1:0] rd_words [NCH];
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   mbox_rx_decode #(
      .ADDR_W      (ADDR_W),
      .INST_SHIFT  (INST_SHIFT),
      .INST_W      (INST_W),
      .SND_SHIFT   (SND_SHIFT),
      .SND_W       (SND_W),
      .NUM_SENDERS (NUM_SENDERS)
   ) u_dec (
      .addr (bus_addr),
      .hit  (dec_hit),
      .chan (dec_chan),
      .kind (dec_kind)
   );

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
         assign chan_hit[ch] = bus_sel && dec_hit && (dec_chan == CH_W'(ch));

         mbox_rx_channel #(
            .FLAG_W         (FLAG_W),
            .DATA_W         (DATA_W),
            .CAPTURE_MIRROR (CAPTURE_MIRROR)
         ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_hit   (chan_hit[ch]),
            .acc_we    (bus_we),
            .acc_kind  (dec_kind),
            .acc_wdata (bus_wdata),
            .set_pulse (evt_set[ch*FLAG_W +: FLAG_W]),
            .cmd_in    (snd_cmd[ch*DATA_W +: DATA_W]),
            .adr_in    (snd_addr[ch*DATA_W +: DATA_W]),
            .dat_in    (snd_data[ch*DATA_W +: DATA_W]),
            .rd_word   (rd_words[ch]),
            .irq       (irq[ch]),
            .reply_out (reply_word[ch*DATA_W +: DATA_W])
         );
      end
   endgenerate

   // unselected channels return zero, so an OR tree forms the mux
   always_comb begin
      rd_mux = '0;
      for (int ch = 0; ch < NCH; ch++) rd_mux = rd_mux | rd_words[ch];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 rdata_q <= '0;
      else if (bus_sel && !bus_we) rdata_q <= rd_mux;
      else                         rdata_q <= '0;
   end

   assign bus_rdata = rdata_q;

   // R7: an access never reaches more than one channel
   a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_hit));

   // R10: no read request means zero read data on the next cycle
   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && !bus_we) |=> (bus_rdata == '0));

   // R4: the acknowledge register reads back as zero
   a_r4_ack_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && dec_kind == RK_ACK) |=> (bus_rdata == '0));

   // R8: reserved offsets read back as zero
   a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && dec_kind == RK_NONE) |=> (bus_rdata == '0));

endmodule

// File: tb/tb_mbox_rx_port.sv
`timescale 1ns/1ps
module tb_mbox_rx_port;

   localparam int NCH = 8;
   localparam int W   = 32;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               bus_sel = 1'b0;
   logic               bus_we = 1'b0;
   logic [13:0]        bus_addr = '0;
   logic [W-1:0]       bus_wdata = '0;
   logic [W-1:0]       bus_rdata;
   logic [NCH*W-1:0]   evt_set = '0;
   logic [NCH*W-1:0]   snd_cmd = '0;
   logic [NCH*W-1:0]   snd_addr = '0;
   logic [NCH*W-1:0]   snd_data = '0;
   logic [NCH*W-1:0]   reply_word;
   logic [NCH-1:0]     irq;

   int tests = 0;
   int fails = 0;
   bit checking = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   mbox_rx_port dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .evt_set    (evt_set),
      .snd_cmd    (snd_cmd),
      .snd_addr   (snd_addr),
      .snd_data   (snd_data),
      .reply_word (reply_word),
      .irq        (irq)
   );

   // ---------------- behavioural reference model ----------------
   logic [W-1:0] m_flags [NCH];
   logic [W-1:0] m_cmd   [NCH];
   logic [W-1:0] m_adr   [NCH];
   logic [W-1:0] m_dat   [NCH];
   logic [W-1:0] m_reply [NCH];
   logic [W-1:0] m_rdata;
   int           m_rtag;

   function automatic int mch(input logic [13:0] a);
      return int'(a) / 'h800;
   endfunction

   function automatic int moff(input logic [13:0] a);
      return int'(a) % 'h800;
   endfunction

   function automatic logic [W-1:0] mread(input logic [13:0] a);
      int c = mch(a);
      case (moff(a))
         'h00: return m_flags[c];
         'h10: return m_cmd[c];
         'h14: return m_adr[c];
         'h18: return m_dat[c];
         'h1C: return m_reply[c];
         default: return '0;
      endcase
   endfunction

   function automatic int mtag(input logic [13:0] a);
      case (moff(a))
         'h00: return 1;
         'h04: return 4;
         'h10, 'h14, 'h18: return 5;
         'h1C: return 6;
         default: return 8;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            m_flags[i] <= '0;
            m_cmd[i]   <= '0;
            m_adr[i]   <= '0;
            m_dat[i]   <= '0;
            m_reply[i] <= '0;
         end
         m_rdata <= '0;
         m_rtag  <= 10;
      end else begin
         for (int i = 0; i < NCH; i++) begin
            logic [W-1:0] clr;
            clr = '0;
            if (bus_sel && bus_we && mch(bus_addr) == i && moff(bus_addr) == 'h04)
               clr = bus_wdata;
            m_flags[i] <= (m_flags[i] & ~clr) | evt_set[i*W +: W];
            m_cmd[i]   <= snd_cmd[i*W +: W];
            m_adr[i]   <= snd_addr[i*W +: W];
            m_dat[i]   <= snd_data[i*W +: W];
            if (bus_sel && bus_we && mch(bus_addr) == i && moff(bus_addr) == 'h1C)
               m_reply[i] <= bus_wdata;
         end
         if (bus_sel && !bus_we) begin
            m_rdata <= mread(bus_addr);
            m_rtag  <= mtag(bus_addr);
         end else begin
            m_rdata <= '0;
            m_rtag  <= 10;
         end
      end
   end

   task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp,
                      input string tag, input string what);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // every-cycle comparison, 1 ns after the rising edge
   always @(posedge clk) begin
      #1;
      if (checking) begin
         chk(bus_rdata, m_rdata, $sformatf("R%0d", m_rtag), "model read data");
         for (int i = 0; i < NCH; i++) begin
            chk(W'(irq[i]), W'(m_flags[i][0]), "R9", $sformatf("model irq ch%0d", i));
            chk(reply_word[i*W +: W], m_reply[i], "R6", $sformatf("model reply ch%0d", i));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle_bus();
      bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic bwr(input logic [13:0] a, input logic [W-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      idle_bus();
   endtask

   task automatic brd(input logic [13:0] a, input logic [W-1:0] exp,
                      input string tag, input string what);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      idle_bus();
      chk(bus_rdata, exp, tag, what);
   endtask

   task automatic pulse(input int c, input logic [W-1:0] m);
      @(negedge clk);
      evt_set[c*W +: W] = m;
      @(negedge clk);
      evt_set = '0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R10 watchdog: actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      checking = 1'b1;

      // reset state
      brd(14'h0000, 32'h0, "R1", "status after reset");
      brd(14'h381C, 32'h0, "R6", "reply after reset");
      brd(14'h2810, 32'h0, "R5", "command mirror after reset");
      chk(W'(irq), 32'h0, "R9", "irq after reset");

      // set and acknowledge on channel 0
      pulse(0, 32'h0000_0005);
      brd(14'h0000, 32'h5, "R1", "status after set pulse");
      chk(W'(irq[0]), 32'h1, "R9", "irq high with flag 0");
      bwr(14'h0004, 32'h0000_0004);
      brd(14'h0000, 32'h1, "R2", "ack clears only bit 2");
      bwr(14'h0004, 32'h0);
      brd(14'h0000, 32'h1, "R2", "ack of zero has no effect");
      brd(14'h0004, 32'h0, "R4", "ack reads zero");

      // coincident set and clear of flag 0
      @(negedge clk);
      evt_set[0 +: W] = 32'h1;
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 14'h0004; bus_wdata = 32'h1;
      @(negedge clk);
      evt_set = '0;
      idle_bus();
      brd(14'h0000, 32'h1, "R3", "set wins over clear");
      bwr(14'h0004, 32'h1);
      chk(W'(irq[0]), 32'h0, "R9", "irq dropped after ack");

      // mirrors of channel 5 (sender 1, instance 1)
      @(negedge clk);
      snd_cmd[5*W +: W]  = 32'hCAFE_0001;
      snd_addr[5*W +: W] = 32'h8000_1234;
      snd_data[5*W +: W] = 32'h0BAD_F00D;
      brd(14'h2810, 32'hCAFE_0001, "R5", "command mirror");
      brd(14'h2814, 32'h8000_1234, "R5", "address mirror");
      brd(14'h2818, 32'h0BAD_F00D, "R5", "data mirror");
      bwr(14'h2810, 32'hFFFF_FFFF);
      brd(14'h2810, 32'hCAFE_0001, "R5", "write to mirror ignored");

      // reply word
      bwr(14'h281C, 32'h1234_5678);
      brd(14'h281C, 32'h1234_5678, "R6", "reply read back");
      chk(reply_word[5*W +: W], 32'h1234_5678, "R6", "reply output");
      chk(reply_word[4*W +: W], 32'h0, "R7", "neighbour reply untouched");

      // reserved offsets and read-only status
      bwr(14'h2808, 32'hFFFF_FFFF);
      brd(14'h2808, 32'h0, "R8", "reserved offset reads zero");
      brd(14'h000C, 32'h0, "R8", "offset 0xC reads zero");
      brd(14'h0011, 32'h0, "R8", "unaligned offset reads zero");
      brd(14'h0020, 32'h0, "R8", "offset 0x20 reads zero");
      bwr(14'h2800, 32'hFFFF_FFFF);
      brd(14'h2800, 32'h0, "R8", "status write ignored");
      chk(W'(irq), 32'h0, "R8", "no irq after ignored writes");

      // channel address map
      @(negedge clk);
      for (int c = 0; c < NCH; c++) evt_set[c*W +: W] = W'((c + 1) << 4);
      @(negedge clk);
      evt_set = '0;
      for (int c = 0; c < NCH; c++)
         brd(14'((c / 4) * 'h2000 + (c % 4) * 'h800), W'((c + 1) << 4), "R7",
             $sformatf("status of channel %0d", c));
      for (int c = 0; c < NCH; c++)
         bwr(14'((c / 4) * 'h2000 + (c % 4) * 'h800 + 4), 32'hFFFF_FFFF);
      @(negedge clk);
      chk(bus_rdata, 32'h0, "R10", "idle read data zero");

      // mixed traffic against the model
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         for (int c = 0; c < NCH; c++) begin
            evt_set[c*W +: W]  = $urandom & $urandom & $urandom;
            snd_cmd[c*W +: W]  = $urandom;
            snd_data[c*W +: W] = $urandom;
         end
         if (($urandom % 3) != 0) begin
            int offs [8] = '{'h00, 'h04, 'h08, 'h10, 'h14, 'h18, 'h1C, 'h24};
            bus_sel   = 1'b1;
            bus_we    = 1'($urandom % 2);
            bus_addr  = 14'(($urandom % NCH) * 'h800 + offs[$urandom % 8]);
            bus_wdata = $urandom;
         end else begin
            idle_bus();
         end
      end
      @(negedge clk);
      evt_set = '0;
      idle_bus();
      repeat (3) @(negedge clk);

      done = 1'b1;
      checking = 1'b0;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule